// File: doc/BRIEF.md
# Instruction Fetch Burst Sequencer

This block reads one instruction at a time from memory for a script processor. A fetch request brings in the start address. The block then runs a bus master through one or more read accesses and hands each returned longword to the decoder. Each longword goes out with a strobe and its position within the instruction. How many longwords an instruction needs depends on its class. An outside decoder reports the class from the first longword, and the block samples it at the moment that longword comes back.

When burst fetch is in force, the first two longwords share one two-beat access. Any longwords beyond those are fetched in new bus ownerships, and the instruction class decides how they are split. A table-indirect block move takes a second two-beat access. A memory move or an indirect instruction takes one single-beat access. Burst fetch is in force only when the enable is set and prefetching is off. In every other case each longword gets its own single-beat ownership. The bus request is dropped for at least one cycle between ownerships. A bus error cancels the fetch.

Top module: `ifetch_burst_seq`

## Requirements
- R1: After reset, bus_req, lw_valid, fetch_done, fetch_err and busy are all low.
- R2: A fetch_req seen while idle starts a fetch at fetch_addr. fetch_req is ignored while a fetch is in progress. bus_req stays high, with bus_addr and bus_len unchanged, until bus_ack is seen.
- R3: In burst mode (burst_en=1 and prefetch_en=0), the first access of every fetch has bus_len=2.
- R4: The class flags are sampled only with the first returned longword. Priority is table-indirect move over memory move over indirect. The instruction length is 4 longwords for a table-indirect move, 3 for a memory move or an indirect instruction, and 2 otherwise.
- R5: In burst mode, the third longword of a memory move or an indirect instruction is read in a separate single-beat access (bus_len=1).
- R6: In burst mode, a table-indirect move is read as two accesses of bus_len=2.
- R7: When not in burst mode (burst_en=0 or prefetch_en=1), every longword is its own access with bus_len=1, and burst_en has no effect.
- R8: The access that starts at longword k has bus_addr = start address + 4*k.
- R9: Between two accesses of the same fetch, bus_req is low for at least one cycle.
- R10: Each beat accepted with rd_valid shows up in the next cycle on lw_data, with lw_valid high and lw_index equal to its longword number. fetch_done pulses together with the last longword.
- R11: rd_err during the data phase ends the fetch. In the next cycle fetch_err pulses for one cycle, and busy, lw_valid and fetch_done are low. No further access is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Start an instruction fetch |
| fetch_addr | input | AW | Start address of the instruction |
| burst_en | input | 1 | Burst fetch enable |
| prefetch_en | input | 1 | Prefetching active; forces single-beat accesses |
| cls_mem_move | input | 1 | Decoder flag: memory-to-memory move |
| cls_indirect | input | 1 | Decoder flag: indirect instruction |
| cls_tbl_move | input | 1 | Decoder flag: table-indirect block move |
| bus_ack | input | 1 | Bus accepts the current request |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | DW | Read data beat |
| rd_err | input | 1 | Bus error response |
| bus_req | output | 1 | Read request / ownership held |
| bus_addr | output | AW | Address of the access |
| bus_len | output | 2 | Beats in the access (1 or 2) |
| lw_valid | output | 1 | Instruction longword valid |
| lw_data | output | DW | Instruction longword |
| lw_index | output | 2 | Position of the longword in the instruction |
| fetch_done | output | 1 | Last longword delivered |
| fetch_err | output | 1 | Fetch aborted by bus error |
| busy | output | 1 | Fetch in progress |

## Verification
The assertions check the following on every cycle:
- the access length is always legal;
- outside burst mode every access has length one;
- a request is held stable until it is accepted;
- ownership is released after each access;
- an abort never coincides with completion or with data.

Only the bench scenarios can show that the sequence of accesses is correct for each class, including the address of each access and the split into bursts. The same holds for the class priority, the sampling of the flags on the first beat only, the prefetch override, and the data ordering on the longword output.

// File: rtl/ifb_pkg.sv
package ifb_pkg;
  localparam int LW_CW = 3;

  typedef enum logic [1:0] {CLS_PLAIN, CLS_MEMMOVE, CLS_INDIRECT, CLS_TABLE} ifb_class_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DATA, ST_GAP} ifb_state_e;

  function automatic ifb_class_e ifb_classify(input logic mm, input logic ind, input logic tbl);
    if (tbl)      return CLS_TABLE;
    else if (mm)  return CLS_MEMMOVE;
    else if (ind) return CLS_INDIRECT;
    return CLS_PLAIN;
  endfunction

  function automatic logic [LW_CW-1:0] ifb_total_lw(input ifb_class_e c);
    case (c)
      CLS_TABLE:    return LW_CW'(4);
      CLS_MEMMOVE,
      CLS_INDIRECT: return LW_CW'(3);
      default:      return LW_CW'(2);
    endcase
  endfunction

  function automatic logic [1:0] ifb_next_len(input logic burst, input ifb_class_e c,
                                              input logic [LW_CW-1:0] got,
                                              input logic [LW_CW-1:0] total);
    logic [LW_CW-1:0] remain;
    remain = total - got;
    if (!burst)                                    return 2'd1;
    else if (got == '0)                            return 2'd2;
    else if (c == CLS_TABLE && remain >= LW_CW'(2)) return 2'd2;
    return 2'd1;
  endfunction
endpackage

// File: rtl/ifb_class_hold.sv
module ifb_class_hold
  import ifb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       cls_mem_move,
  input  logic       cls_indirect,
  input  logic       cls_tbl_move,
  output ifb_class_e class_eff
);
  ifb_class_e class_q;
  ifb_class_e class_live;

  assign class_live = ifb_classify(cls_mem_move, cls_indirect, cls_tbl_move);
  assign class_eff  = load ? class_live : class_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    class_q <= CLS_PLAIN;
    else if (load) class_q <= class_live;
  end
endmodule

// File: rtl/ifb_lw_out.sv
module ifb_lw_out #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] data_in,
  input  logic [1:0]    index_in,
  input  logic          done_in,
  input  logic          err_in,
  output logic          lw_valid,
  output logic [DW-1:0] lw_data,
  output logic [1:0]    lw_index,
  output logic          fetch_done,
  output logic          fetch_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lw_valid   <= 1'b0;
      lw_data    <= '0;
      lw_index   <= '0;
      fetch_done <= 1'b0;
      fetch_err  <= 1'b0;
    end else begin
      lw_valid   <= take;
      fetch_done <= done_in;
      fetch_err  <= err_in;
      if (take) begin
        lw_data  <= data_in;
        lw_index <= index_in;
      end
    end
  end

  // R10: completion is always reported alongside a longword
  p_done_with_lw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |-> lw_valid);
  // R11: an aborted fetch delivers no data and no completion
  p_err_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_err |-> (!lw_valid && !fetch_done));
endmodule

// File: rtl/ifetch_burst_seq.sv
module ifetch_burst_seq
  import ifb_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  input  logic          burst_en,
  input  logic          prefetch_en,
  input  logic          cls_mem_move,
  input  logic          cls_indirect,
  input  logic          cls_tbl_move,
  input  logic          bus_ack,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_err,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_len,
  output logic          lw_valid,
  output logic [DW-1:0] lw_data,
  output logic [1:0]    lw_index,
  output logic          fetch_done,
  output logic          fetch_err,
  output logic          busy
);
  localparam int PAD = AW - LW_CW - 2;

  function automatic logic [AW-1:0] lw_addr(input logic [AW-1:0] base, input logic [LW_CW-1:0] idx);
    return base + {{PAD{1'b0}}, idx, 2'b00};
  endfunction

  ifb_state_e       state;
  logic             mode_q;
  logic [AW-1:0]    base_q;
  logic [LW_CW-1:0] lw_cnt;
  logic [1:0]       beat_cnt;
  logic [1:0]       cur_len;
  ifb_class_e       class_eff;
  logic [LW_CW-1:0] total_eff;

  // named internal events
  logic first_beat, beat_take, err_abort, last_beat, fetch_end, acc_end;

  assign beat_take  = (state == ST_DATA) && rd_valid && !rd_err;
  assign err_abort  = (state == ST_DATA) && rd_err;
  assign first_beat = beat_take && (lw_cnt == '0);
  assign total_eff  = ifb_total_lw(class_eff);
  assign last_beat  = beat_take && (beat_cnt == cur_len - 2'd1);
  assign fetch_end  = last_beat && ((lw_cnt + LW_CW'(1)) == total_eff);
  assign acc_end    = last_beat && !fetch_end;

  ifb_class_hold u_class (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (first_beat),
    .cls_mem_move (cls_mem_move),
    .cls_indirect (cls_indirect),
    .cls_tbl_move (cls_tbl_move),
    .class_eff    (class_eff)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode_q   <= 1'b0;
      base_q   <= '0;
      lw_cnt   <= '0;
      beat_cnt <= '0;
      cur_len  <= 2'd1;
    end else begin
      case (state)
        ST_IDLE: if (fetch_req) begin
          state  <= ST_REQ;
          mode_q <= burst_en & ~prefetch_en;
          base_q <= fetch_addr;
          lw_cnt <= '0;
        end
        ST_REQ: if (bus_ack) begin
          state    <= ST_DATA;
          cur_len  <= bus_len;
          beat_cnt <= '0;
        end
        ST_DATA: begin
          if (err_abort) begin
            state <= ST_IDLE;
          end else if (beat_take) begin
            lw_cnt   <= lw_cnt + LW_CW'(1);
            beat_cnt <= beat_cnt + 2'd1;
            if (fetch_end)    state <= ST_IDLE;
            else if (acc_end) state <= ST_GAP;
          end
        end
        default: state <= ST_REQ;
      endcase
    end
  end

  assign bus_req  = (state == ST_REQ);
  assign bus_addr = lw_addr(base_q, lw_cnt);
  assign bus_len  = ifb_next_len(mode_q, class_eff, lw_cnt, total_eff);
  assign busy     = (state != ST_IDLE);

  ifb_lw_out #(.DW(DW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (beat_take),
    .data_in    (rd_data),
    .index_in   (lw_cnt[1:0]),
    .done_in    (fetch_end),
    .err_in     (err_abort),
    .lw_valid   (lw_valid),
    .lw_data    (lw_data),
    .lw_index   (lw_index),
    .fetch_done (fetch_done),
    .fetch_err  (fetch_err)
  );

  p_len_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_len == 2'd1 || bus_len == 2'd2));
  p_single_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !mode_q) |-> (bus_len == 2'd1));
  p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_len)));
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_end |=> !bus_req);
  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_abort |=> (!busy && fetch_err && !bus_req));
endmodule

// File: tb/ifetch_burst_seq_bench.sv
module ifetch_burst_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 7;

  // {burst_en, prefetch_en, mem_move, indirect, tbl_move, start address}
  localparam logic [36:0] VECS [0:NVEC-1] = '{
    {5'b10000, 32'h0000_1000},
    {5'b10100, 32'h0000_2000},
    {5'b10010, 32'h0000_3004},
    {5'b10001, 32'h0000_4008},
    {5'b00001, 32'h0000_5000},
    {5'b11100, 32'h0000_6000},
    {5'b10111, 32'h0000_7000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        burst_en = 1'b0, prefetch_en = 1'b0;
  logic        cls_mem_move = 1'b0, cls_indirect = 1'b0, cls_tbl_move = 1'b0;
  logic        bus_ack = 1'b0, rd_valid = 1'b0, rd_err = 1'b0;
  logic [31:0] rd_data = '0;
  logic        bus_req, lw_valid, fetch_done, fetch_err, busy;
  logic [31:0] bus_addr, lw_data;
  logic [1:0]  bus_len, lw_index;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifetch_burst_seq u_ifetch_burst_seq (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .burst_en(burst_en), .prefetch_en(prefetch_en), .cls_mem_move(cls_mem_move),
    .cls_indirect(cls_indirect), .cls_tbl_move(cls_tbl_move), .bus_ack(bus_ack),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_len(bus_len), .lw_valid(lw_valid), .lw_data(lw_data),
    .lw_index(lw_index), .fetch_done(fetch_done), .fetch_err(fetch_err), .busy(busy)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input logic [31:0] a, input int k);
    return a ^ 32'hA5A5_0000 ^ 32'(k * 17);
  endfunction

  // Runs one fetch with the bench acting as memory; checks the access plan.
  task automatic run_fetch(input logic [36:0] v);
    logic be, pf, mm, ind, tb, mode;
    logic [31:0] a;
    int tot, nacc, lw;
    int lens [4];
    {be, pf, mm, ind, tb, a} = v;
    mode = be && !pf;
    tot  = tb ? 4 : ((mm || ind) ? 3 : 2);
    if (!mode) begin
      nacc = tot;
      for (int i = 0; i < 4; i++) lens[i] = 1;
    end else if (tb) begin
      nacc = 2; lens = '{2, 2, 0, 0};
    end else if (tot == 3) begin
      nacc = 2; lens = '{2, 1, 0, 0};
    end else begin
      nacc = 1; lens = '{2, 0, 0, 0};
    end
    @(negedge clk);
    burst_en = be; prefetch_en = pf; fetch_addr = a; fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
    lw = 0;
    for (int acc = 0; acc < nacc; acc++) begin
      chk("R2", "bus_req raised", 32'(bus_req), 32'd1);
      chk("R8", "access address", bus_addr, a + 32'(4 * lw));
      chk(!mode ? "R7" : (tb ? "R6" : (acc == 0 ? "R3" : "R5")), "access length",
          32'(bus_len), 32'(lens[acc]));
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
      for (int b = 0; b < lens[acc]; b++) begin
        rd_valid = 1'b1;
        rd_data  = pattern(a, lw);
        cls_mem_move = (lw == 0) ? mm : 1'b0;
        cls_indirect = (lw == 0) ? ind : 1'b0;
        cls_tbl_move = (lw == 0) ? tb : 1'b0;
        @(negedge clk);
        rd_valid = 1'b0;
        {cls_mem_move, cls_indirect, cls_tbl_move} = 3'b000;
        chk("R10", "lw_valid", 32'(lw_valid), 32'd1);
        chk("R10", "lw_data", lw_data, pattern(a, lw));
        chk("R10", "lw_index", 32'(lw_index), 32'(lw));
        lw++;
        chk("R4", "fetch_done at longword", 32'(fetch_done), 32'(lw == tot));
      end
      if (acc < nacc - 1) begin
        chk("R9", "ownership released", 32'(bus_req), 32'd0);
        @(negedge clk);
      end
    end
    chk("R4", "idle after instruction", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R2", "no request after fetch", 32'(bus_req), 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "bus_req", 32'(bus_req), 32'd0);
    chk("R1", "lw_valid", 32'(lw_valid), 32'd0);
    chk("R1", "fetch_done", 32'(fetch_done), 32'd0);
    chk("R1", "fetch_err", 32'(fetch_err), 32'd0);
    chk("R1", "busy", 32'(busy), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) run_fetch(VECS[i]);

    // R2: slow grant holds the request; fetch_req while busy is ignored
    @(negedge clk);
    burst_en = 1'b1; prefetch_en = 1'b0; fetch_addr = 32'h0000_0100; fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
    for (int w = 0; w < 3; w++) begin
      chk("R2", "request held", 32'(bus_req), 32'd1);
      chk("R2", "address held", bus_addr, 32'h0000_0100);
      @(negedge clk);
    end
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
    rd_valid = 1'b1; rd_data = 32'h1111_0000;
    fetch_req = 1'b1; fetch_addr = 32'h0000_9000;
    @(negedge clk);
    fetch_req = 1'b0; rd_data = 32'h1111_0001;
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R2", "plain fetch done", 32'(fetch_done), 32'd1);
    @(negedge clk);
    chk("R2", "busy fetch_req ignored", 32'(bus_req), 32'd0);
    chk("R2", "busy fetch_req ignored busy", 32'(busy), 32'd0);

    // R11: bus error on second beat of a memory move
    @(negedge clk);
    burst_en = 1'b1; fetch_addr = 32'h0000_0200; fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0; bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0; rd_valid = 1'b1; rd_data = 32'h2222_0000; cls_mem_move = 1'b1;
    @(negedge clk);
    cls_mem_move = 1'b0; rd_err = 1'b1; rd_data = 32'h2222_0001;
    @(negedge clk);
    rd_valid = 1'b0; rd_err = 1'b0;
    chk("R11", "fetch_err", 32'(fetch_err), 32'd1);
    chk("R11", "busy", 32'(busy), 32'd0);
    chk("R11", "fetch_done", 32'(fetch_done), 32'd0);
    chk("R11", "lw_valid", 32'(lw_valid), 32'd0);
    @(negedge clk);
    chk("R11", "fetch_err one cycle", 32'(fetch_err), 32'd0);
    chk("R11", "no further request", 32'(bus_req), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule